// File: doc/BRIEF.md
# Micro-Op Dispatch Arbiter

This block picks ready micro-ops out of a reservation-station array and issues up to five of them per cycle, one on each issue port. The ports are not alike. Port 0 feeds both the full integer unit and the floating-point unit. Port 1 feeds a reduced integer unit. Ports 2, 3 and 4 each serve a single memory micro-op kind: load, store address and store data.

Each entry presents a valid bit, a ready bit, a class code, a precision code and an age. Within every port, the oldest eligible entry wins. For port 0 the block also keeps a countdown for the non-pipelined divide/square-root unit. In addition it keeps a vector of reserved write-back cycles, so that two port-0 results never complete in the same cycle.

Grants are registered and appear one cycle after the inputs they were computed from. The surrounding station is expected to retire granted entries before the next edge.

Top module: `uop_dispatch_arb`

## Requirements
- R1: Port 1 (grant slot 1) grants only class 0 (simple integer: add, subtract, branch target).
- R2: Port 0 (grant slot 0) grants at most one micro-op per cycle, of class 0 to 5. Class 1 (shift, multiply, integer divide, address computation), 2 (FP add), 3 (FP multiply), 4 (FP divide) and 5 (FP square root) are granted on no other port.
- R3: Class 6 (load) is granted only on slot 2, class 7 (store address) only on slot 3 and class 8 (store data) only on slot 4.
- R4: On each port the winner is the eligible entry with the smallest age value; on equal ages the lower entry index wins.
- R5: The oldest eligible class-0 entry goes to port 1. Port 0 takes a class-0 entry only when it has no eligible class 1 to 5 entry, and then takes the oldest class-0 entry other than the port-1 winner.
- R6: After a class 4 or 5 grant of latency L, no further class 4 or 5 grant is made until L cycles later, and one may be made exactly L cycles later. L is 18/27/36 for divide and 29/49/69 for square root, for precision code 0 (32-bit), 1 (64-bit) and 2 or 3 (80-bit).
- R7: A divide or square root in progress does not hold back class 0 to 3 grants on port 0.
- R8: Port-0 result latency is 1 for classes 0 and 1, 3 for FP add, 5 for FP multiply and L for divide/square root. An entry whose completion cycle is already reserved by an earlier port-0 grant is not eligible for port 0.
- R9: No entry index is granted on two ports in the same cycle.
- R10: Grants change only at the clock edge after the inputs they follow, and reset clears all grants, the divider countdown and the reservations.
- R11: Entries that are not valid, not ready, or carry a class code of 9 to 15 are never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_valid | input | NUM_ENT | Entry holds a micro-op |
| ent_ready | input | NUM_ENT | Entry operands are available |
| ent_cls | input | NUM_ENT*4 | Class code per entry, entry i at bits [4i+3:4i] |
| ent_prec | input | NUM_ENT*2 | Precision code per entry |
| ent_age | input | NUM_ENT*AGE_W | Age per entry, smaller is older |
| gnt_vld | output | 5 | Grant valid per port, bit p for port p |
| gnt_idx | output | 5*IDX_W | Granted entry index, port p at bits [p*IDX_W +: IDX_W] |

## Verification
Two situations are the hardest to reach from the ports. One is a write-back collision, where a port-0 candidate is held back only because an older grant of different latency will finish in the same cycle. The other is the exact cycle at which the divider frees up after a long square root. Directed sequences build both. A multiply is followed two cycles later by an add to force the collision. A square root or divide is followed by a second one, and the bench counts the cycles until the second is granted. Seeded random traffic then mixes all classes, precisions, ready patterns and illegal codes against a bench model of the arbitration rules. This reaches the rarer overlaps of divider latency with add and multiply reservations.

// File: rtl/uop_disp_pkg.sv
package uop_disp_pkg;
  localparam int CLS_W     = 4;
  localparam int PREC_W    = 2;
  localparam int LAT_W     = 7;
  localparam int NUM_PORTS = 5;
  localparam int MAX_LAT   = 69;
  localparam int WB_DEPTH  = MAX_LAT + 2;

  localparam logic [CLS_W-1:0] C_ALU   = 4'd0;
  localparam logic [CLS_W-1:0] C_CPLX  = 4'd1;
  localparam logic [CLS_W-1:0] C_FADD  = 4'd2;
  localparam logic [CLS_W-1:0] C_FMUL  = 4'd3;
  localparam logic [CLS_W-1:0] C_FDIV  = 4'd4;
  localparam logic [CLS_W-1:0] C_FSQRT = 4'd5;
  localparam logic [CLS_W-1:0] C_LOAD  = 4'd6;
  localparam logic [CLS_W-1:0] C_STA   = 4'd7;
  localparam logic [CLS_W-1:0] C_STD   = 4'd8;

  // completion latency of a port-0 micro-op
  function automatic logic [LAT_W-1:0] p0_latency(input logic [CLS_W-1:0] c,
                                                  input logic [PREC_W-1:0] p);
    logic [LAT_W-1:0] l;
    case (c)
      C_FADD:  l = 7'd3;
      C_FMUL:  l = 7'd5;
      C_FDIV:  l = (p == 2'd0) ? 7'd18 : (p == 2'd1) ? 7'd27 : 7'd36;
      C_FSQRT: l = (p == 2'd0) ? 7'd29 : (p == 2'd1) ? 7'd49 : 7'd69;
      default: l = 7'd1;
    endcase
    return l;
  endfunction

  function automatic logic uses_divider(input logic [CLS_W-1:0] c);
    return (c == C_FDIV) || (c == C_FSQRT);
  endfunction
endpackage

// File: rtl/uop_oldest_pick.sv
module uop_oldest_pick #(
  parameter int NUM_ENT = 8,
  parameter int AGE_W   = 4,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0]       req_i,
  input  logic [NUM_ENT*AGE_W-1:0] age_i,
  output logic                     vld_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [AGE_W-1:0] best_age;

  always_comb begin
    vld_o    = 1'b0;
    idx_o    = '0;
    best_age = '1;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (req_i[i] && (!vld_o || age_i[i*AGE_W +: AGE_W] < best_age)) begin
        vld_o    = 1'b1;
        idx_o    = IDX_W'(i);
        best_age = age_i[i*AGE_W +: AGE_W];
      end
    end
  end
endmodule

// File: rtl/div_busy_track.sv
module div_busy_track #(
  parameter int LAT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             busy_o
);
  logic [LAT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)               remain <= '0;
    else if (start_i)      remain <= lat_i - 1'b1;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy_o = (remain != '0);
endmodule

// File: rtl/wb_slot_rsv.sv
module wb_slot_rsv #(
  parameter int DEPTH = 71,
  parameter int LAT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic [DEPTH-1:0] taken_o
);
  // bit k set: a port-0 result completes k edges after the latest edge
  always_ff @(posedge clk) begin
    if (rst) taken_o <= '0;
    else     taken_o <= (taken_o >> 1) | (set_i ? (DEPTH'(1) << lat_i) : '0);
  end
endmodule

// File: rtl/uop_dispatch_arb.sv
module uop_dispatch_arb
  import uop_disp_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int AGE_W   = 4,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_ENT-1:0]           ent_valid,
  input  logic [NUM_ENT-1:0]           ent_ready,
  input  logic [NUM_ENT*CLS_W-1:0]     ent_cls,
  input  logic [NUM_ENT*PREC_W-1:0]    ent_prec,
  input  logic [NUM_ENT*AGE_W-1:0]     ent_age,
  output logic [NUM_PORTS-1:0]         gnt_vld,
  output logic [NUM_PORTS*IDX_W-1:0]   gnt_idx
);
  localparam int NUM_LSU = 3;

  logic [WB_DEPTH-1:0]           wb_taken;
  logic                          div_busy;
  logic [NUM_ENT-1:0]            req_p1, req_p0x, alu_p0, req_p0a;
  logic [NUM_LSU-1:0][NUM_ENT-1:0] req_lsu;
  logic                          p1_vld, p0x_vld, p0a_vld, p0_vld;
  logic [IDX_W-1:0]              p1_idx, p0x_idx, p0a_idx, p0_idx;
  logic [NUM_LSU-1:0]            lsu_vld;
  logic [IDX_W-1:0]              lsu_idx [NUM_LSU];
  logic [CLS_W-1:0]              p0_cls;
  logic [LAT_W-1:0]              p0_lat;
  logic                          p0_div;

  // eligibility masks per port
  always_comb begin
    req_p1  = '0;
    req_p0x = '0;
    alu_p0  = '0;
    req_lsu = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      logic [CLS_W-1:0] c;
      logic [LAT_W-1:0] l;
      logic             live, slot_ok;
      c       = ent_cls[i*CLS_W +: CLS_W];
      l       = p0_latency(c, ent_prec[i*PREC_W +: PREC_W]);
      live    = ent_valid[i] & ent_ready[i];
      slot_ok = !wb_taken[l + 7'd1];
      req_p1[i]  = live && (c == C_ALU);
      alu_p0[i]  = live && (c == C_ALU) && slot_ok;
      req_p0x[i] = live && slot_ok &&
                   ((c == C_CPLX) || (c == C_FADD) || (c == C_FMUL) ||
                    (uses_divider(c) && !div_busy));
      for (int k = 0; k < NUM_LSU; k++)
        req_lsu[k][i] = live && (c == C_LOAD + CLS_W'(k));
    end
  end

  uop_oldest_pick #(.NUM_ENT(NUM_ENT), .AGE_W(AGE_W)) u_pick_p1 (
    .req_i(req_p1), .age_i(ent_age), .vld_o(p1_vld), .idx_o(p1_idx));

  uop_oldest_pick #(.NUM_ENT(NUM_ENT), .AGE_W(AGE_W)) u_pick_p0x (
    .req_i(req_p0x), .age_i(ent_age), .vld_o(p0x_vld), .idx_o(p0x_idx));

  // simple integer overflow to port 0, excluding the port-1 winner
  always_comb begin
    req_p0a = alu_p0;
    if (p1_vld) req_p0a[p1_idx] = 1'b0;
  end

  uop_oldest_pick #(.NUM_ENT(NUM_ENT), .AGE_W(AGE_W)) u_pick_p0a (
    .req_i(req_p0a), .age_i(ent_age), .vld_o(p0a_vld), .idx_o(p0a_idx));

  for (genvar k = 0; k < NUM_LSU; k++) begin : g_lsu
    uop_oldest_pick #(.NUM_ENT(NUM_ENT), .AGE_W(AGE_W)) u_pick (
      .req_i(req_lsu[k]), .age_i(ent_age), .vld_o(lsu_vld[k]), .idx_o(lsu_idx[k]));
  end

  assign p0_vld = p0x_vld | p0a_vld;
  assign p0_idx = p0x_vld ? p0x_idx : p0a_idx;
  assign p0_cls = ent_cls[int'(p0_idx)*CLS_W +: CLS_W];
  assign p0_lat = p0_latency(p0_cls, ent_prec[int'(p0_idx)*PREC_W +: PREC_W]);
  assign p0_div = p0_vld && uses_divider(p0_cls);

  div_busy_track #(.LAT_W(LAT_W)) u_div (
    .clk(clk), .rst(rst), .start_i(p0_div), .lat_i(p0_lat), .busy_o(div_busy));

  wb_slot_rsv #(.DEPTH(WB_DEPTH), .LAT_W(LAT_W)) u_wb (
    .clk(clk), .rst(rst), .set_i(p0_vld), .lat_i(p0_lat), .taken_o(wb_taken));

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_vld <= '0;
      gnt_idx <= '0;
    end else begin
      gnt_vld <= {lsu_vld[2], lsu_vld[1], lsu_vld[0], p1_vld, p0_vld};
      gnt_idx <= {lsu_idx[2], lsu_idx[1], lsu_idx[0], p1_idx, p0_idx};
    end
  end
endmodule

// File: rtl/uop_dispatch_arb_chk.sv
module uop_dispatch_arb_chk
  import uop_disp_pkg::*;
#(
  parameter int NUM_ENT = 8,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_ENT-1:0]         ent_valid,
  input logic [NUM_ENT-1:0]         ent_ready,
  input logic [NUM_ENT*CLS_W-1:0]   ent_cls,
  input logic [NUM_PORTS-1:0]       gnt_vld,
  input logic [NUM_PORTS*IDX_W-1:0] gnt_idx
);
  localparam int MIN_DIV = 18;

  logic [NUM_ENT-1:0]       v_q, r_q;
  logic [NUM_ENT*CLS_W-1:0] cls_q;
  logic [CLS_W-1:0]         g_cls [NUM_PORTS];
  logic [NUM_PORTS-1:0]     g_live;
  logic                     div_seen;
  logic [7:0]               gap;

  // inputs seen in the cycle the current grants were computed
  always_ff @(posedge clk) begin
    v_q   <= ent_valid;
    r_q   <= ent_ready;
    cls_q <= ent_cls;
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      g_cls[p]  = cls_q[int'(gnt_idx[p*IDX_W +: IDX_W])*CLS_W +: CLS_W];
      g_live[p] = v_q[gnt_idx[p*IDX_W +: IDX_W]] & r_q[gnt_idx[p*IDX_W +: IDX_W]];
    end
  end

  assign div_seen = gnt_vld[0] && uses_divider(g_cls[0]);

  always_ff @(posedge clk) begin
    if (rst)           gap <= 8'hFF;
    else if (div_seen) gap <= 8'd1;
    else if (gap != 8'hFF) gap <= gap + 8'd1;
  end

  // R1
  p1_cls_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_vld[1] |-> g_cls[1] == C_ALU);
  // R2
  p0_cls_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_vld[0] |-> g_cls[0] <= C_FSQRT);
  // R3
  ld_port_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_vld[2] |-> g_cls[2] == C_LOAD);
  // R3
  sta_port_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_vld[3] |-> g_cls[3] == C_STA);
  // R3
  std_port_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_vld[4] |-> g_cls[4] == C_STD);
  // R6
  div_gap_chk: assert property (@(posedge clk) disable iff (rst)
    div_seen |-> gap >= 8'(MIN_DIV));
  // R9
  distinct_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld[0] && gnt_vld[1]) |-> gnt_idx[0 +: IDX_W] != gnt_idx[IDX_W +: IDX_W]);
  // R10
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> gnt_vld == '0);
  // R11
  gnt_live_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld & ~g_live) == '0);
endmodule

bind uop_dispatch_arb uop_dispatch_arb_chk #(.NUM_ENT(NUM_ENT)) i_chk (
  .clk(clk), .rst(rst), .ent_valid(ent_valid), .ent_ready(ent_ready),
  .ent_cls(ent_cls), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx));

// File: tb/test_uop_dispatch_arb.sv
module test_uop_dispatch_arb;
  localparam int N    = 8;
  localparam int AW   = 4;
  localparam int IW   = 3;
  localparam int WBD  = 72;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [N-1:0]    ent_valid, ent_ready;
  logic [N*4-1:0]  ent_cls;
  logic [N*2-1:0]  ent_prec;
  logic [N*AW-1:0] ent_age;
  logic [4:0]      gnt_vld;
  logic [5*IW-1:0] gnt_idx;

  logic       b_valid [N];
  logic       b_ready [N];
  logic [3:0] b_cls   [N];
  logic [1:0] b_prec  [N];
  int         b_age   [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_valid[i]           = b_valid[i];
      ent_ready[i]           = b_ready[i];
      ent_cls[i*4 +: 4]      = b_cls[i];
      ent_prec[i*2 +: 2]     = b_prec[i];
      ent_age[i*AW +: AW]    = AW'(b_age[i]);
    end
  end

  uop_dispatch_arb #(.NUM_ENT(N), .AGE_W(AW)) i_uop_dispatch_arb (
    .clk(clk), .rst(rst), .ent_valid(ent_valid), .ent_ready(ent_ready),
    .ent_cls(ent_cls), .ent_prec(ent_prec), .ent_age(ent_age),
    .gnt_vld(gnt_vld), .gnt_idx(gnt_idx));

  int n_chk = 0;
  int n_err = 0;
  int exp_p [5];
  int g_v   [5];
  int g_i   [5];
  bit m_rsv [WBD];
  int m_div = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lat_of(input logic [3:0] c, input logic [1:0] p);
    int sel;
    sel = (p == 2'd3) ? 2 : int'(p);
    if (c == 4'd2) return 3;
    if (c == 4'd3) return 5;
    if (c == 4'd4) return 18 + 9 * sel;
    if (c == 4'd5) return 29 + 20 * sel;
    return 1;
  endfunction

  function automatic int oldest(input logic [N-1:0] m);
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m[i] && (b < 0 || b_age[i] < b_age[b])) b = i;
    return b;
  endfunction

  function automatic void predict();
    logic [N-1:0] m1, m0x, m0a, ml, ms, md;
    m1 = '0; m0x = '0; m0a = '0; ml = '0; ms = '0; md = '0;
    for (int i = 0; i < N; i++) begin
      if (b_valid[i] && b_ready[i]) begin
        bit fr;
        fr = !m_rsv[lat_of(b_cls[i], b_prec[i]) + 1];
        m1[i] = (b_cls[i] == 4'd0);
        ml[i] = (b_cls[i] == 4'd6);
        ms[i] = (b_cls[i] == 4'd7);
        md[i] = (b_cls[i] == 4'd8);
        if (b_cls[i] >= 4'd1 && b_cls[i] <= 4'd3 && fr) m0x[i] = 1'b1;
        if ((b_cls[i] == 4'd4 || b_cls[i] == 4'd5) && fr && m_div == 0) m0x[i] = 1'b1;
      end
    end
    exp_p[1] = oldest(m1);
    for (int i = 0; i < N; i++)
      m0a[i] = m1[i] && !m_rsv[2] && (i != exp_p[1]);
    exp_p[0] = oldest(m0x);
    if (exp_p[0] < 0) exp_p[0] = oldest(m0a);
    exp_p[2] = oldest(ml);
    exp_p[3] = oldest(ms);
    exp_p[4] = oldest(md);
  endfunction

  function automatic string ptag(input int p);
    case (p)
      0: return "R2 port0";
      1: return "R1 port1";
      default: return "R3 memory port";
    endcase
  endfunction

  task automatic step();
    predict();
    @(posedge clk);
    #1;
    for (int p = 0; p < 5; p++) begin
      g_v[p] = int'(gnt_vld[p]);
      g_i[p] = int'(gnt_idx[p*IW +: IW]);
      chk((g_v[p] == (exp_p[p] >= 0)) && (exp_p[p] < 0 || g_i[p] == exp_p[p]),
          ptag(p), g_v[p] ? g_i[p] : -1, exp_p[p]);
    end
    for (int k = 0; k < WBD - 1; k++) m_rsv[k] = m_rsv[k+1];
    m_rsv[WBD-1] = 1'b0;
    if (exp_p[0] >= 0) begin
      int l;
      l = lat_of(b_cls[exp_p[0]], b_prec[exp_p[0]]);
      m_rsv[l] = 1'b1;
      if (b_cls[exp_p[0]] == 4'd4 || b_cls[exp_p[0]] == 4'd5) m_div = l - 1;
      else if (m_div > 0) m_div--;
    end else if (m_div > 0) m_div--;
    for (int p = 0; p < 5; p++)
      if (exp_p[p] >= 0) b_valid[exp_p[p]] = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      b_valid[i] = 1'b0; b_ready[i] = 1'b0; b_cls[i] = 4'd0; b_prec[i] = 2'd0; b_age[i] = 0;
    end
  endtask

  task automatic idle(input int n);
    clear_all();
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic put(input int i, input logic [3:0] c, input logic [1:0] p, input int a);
    b_valid[i] = 1'b1; b_ready[i] = 1'b1; b_cls[i] = c; b_prec[i] = p; b_age[i] = a;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int found;
    void'($urandom(32'd4242));
    for (int k = 0; k < WBD; k++) m_rsv[k] = 1'b0;
    clear_all();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(gnt_vld == 5'd0, "R10 reset", int'(gnt_vld), 0);

    // R10: grant appears only after the next edge
    idle(2);
    put(0, 4'd6, 2'd0, 0);
    #1 chk(gnt_vld == 5'd0, "R10 before edge", int'(gnt_vld), 0);
    step();
    chk(g_v[2] == 1 && g_i[2] == 0, "R10 after edge", g_i[2], 0);

    // R4: oldest load, then age tie
    clear_all();
    put(1, 4'd6, 2'd0, 5); put(6, 4'd6, 2'd0, 2);
    step();
    chk(g_i[2] == 6, "R4 oldest", g_i[2], 6);
    clear_all();
    put(5, 4'd6, 2'd0, 4); put(3, 4'd6, 2'd0, 4);
    step();
    chk(g_i[2] == 3, "R4 tie", g_i[2], 3);

    // R3: all memory ports at once
    clear_all();
    put(0, 4'd7, 2'd0, 1); put(1, 4'd8, 2'd0, 1); put(2, 4'd6, 2'd0, 1);
    step();
    chk(g_v[2] && g_i[2] == 2 && g_v[3] && g_i[3] == 0 && g_v[4] && g_i[4] == 1,
        "R3 memory ports", int'(gnt_vld), 28);

    // R5: simple integer steering
    idle(3);
    put(2, 4'd0, 2'd0, 5); put(4, 4'd0, 2'd0, 2); put(6, 4'd3, 2'd0, 9);
    step();
    chk(g_i[1] == 4 && g_i[0] == 6, "R5 alu to port1", g_i[1] * 10 + g_i[0], 46);
    clear_all();
    put(1, 4'd0, 2'd0, 7); put(3, 4'd0, 2'd0, 1);
    step();
    chk(g_v[1] && g_i[1] == 3 && g_v[0] && g_i[0] == 1, "R5 overflow to port0",
        g_i[1] * 10 + g_i[0], 31);
    // R9
    chk(g_i[0] != g_i[1], "R9 distinct", g_i[0], -1);

    // R1 and R2: complex integer never on port 1
    idle(8);
    put(0, 4'd1, 2'd0, 0); put(1, 4'd1, 2'd0, 1);
    step();
    chk(g_v[1] == 0, "R1 no complex on port1", g_v[1], 0);
    chk(g_v[0] && g_i[0] == 0, "R2 complex on port0", g_i[0], 0);
    step();

    // R11: not ready, not valid, bad class
    idle(8);
    put(0, 4'd6, 2'd0, 0); b_ready[0] = 1'b0;
    put(1, 4'd6, 2'd0, 3);
    put(2, 4'd12, 2'd0, 0);
    put(3, 4'd6, 2'd0, 0); b_valid[3] = 1'b0;
    step();
    chk(gnt_vld == 5'b00100 && g_i[2] == 1, "R11 ignored entries", int'(gnt_vld), 4);

    // R8: multiply then add collide on write-back
    idle(10);
    put(0, 4'd3, 2'd0, 0);
    step();
    step();
    put(1, 4'd2, 2'd0, 0);
    step();
    chk(g_v[0] == 0, "R8 collision held", g_v[0], 0);
    step();
    chk(g_v[0] && g_i[0] == 1, "R8 granted next", g_i[0], 1);

    // R6 and R7: single-precision divide gap, add runs alongside
    idle(80);
    put(0, 4'd4, 2'd0, 0);
    step();
    chk(g_v[0] && g_i[0] == 0, "R6 first divide", g_i[0], 0);
    put(1, 4'd4, 2'd0, 0); put(2, 4'd2, 2'd0, 1);
    step();
    chk(g_v[0] && g_i[0] == 2, "R7 add during divide", g_i[0], 2);
    found = -1;
    for (int k = 2; k <= 40 && found < 0; k++) begin
      step();
      if (g_v[0] && g_i[0] == 1) found = k;
    end
    chk(found == 18, "R6 divide gap", found, 18);

    // R6: extended square root gap
    idle(80);
    put(0, 4'd5, 2'd2, 0);
    step();
    put(1, 4'd4, 2'd0, 0);
    found = -1;
    for (int k = 1; k <= 80 && found < 0; k++) begin
      step();
      if (g_v[0] && g_i[0] == 1) found = k;
    end
    chk(found == 69, "R6 sqrt gap", found, 69);

    // random traffic against the model
    clear_all();
    for (int cyc = 0; cyc < 3000; cyc++) begin
      for (int i = 0; i < N; i++) begin
        if (b_valid[i] && ($urandom % 16) == 0) b_valid[i] = 1'b0;
        if (!b_valid[i] && ($urandom % 3) == 0) begin
          int r;
          logic [3:0] c;
          r = $urandom % 20;
          if (r < 5) c = 4'd0;
          else if (r < 7) c = 4'd1;
          else if (r < 9) c = 4'd2;
          else if (r < 11) c = 4'd3;
          else if (r == 11) c = 4'd4;
          else if (r == 12) c = 4'd5;
          else if (r < 16) c = 4'd6;
          else if (r == 16) c = 4'd7;
          else if (r == 17) c = 4'd8;
          else c = 4'(9 + $urandom % 7);
          put(i, c, 2'($urandom % 4), int'($urandom % 16));
        end
        b_ready[i] = (($urandom % 4) != 0);
      end
      step();
    end

    finish_run();
  end
endmodule